// File: doc/BRIEF.md
# Two-Byte Stored-Program Processor Core

This block is a small multi-cycle processor that runs a program held in the same byte-wide memory as its data. Every instruction is two bytes. The core reads both bytes into an instruction register, moves its program counter on to the next instruction, and then carries out the operation. It supports six instructions: move a memory byte into a register, write a register to memory, add two registers, jump always, jump when two registers are equal, and stop. The core keeps four 8-bit general registers, R1 to R4.

The memory port is synchronous. The core presents an address in one cycle and takes the read byte in the next. A write is one cycle with the write strobe set. A test harness watches the halted flag and the program counter. It can read any general register through a select input.

The core executes each instruction in a fixed walk of states:
- fetch the first byte;
- fetch the second byte;
- decode;
- execute;
- for a load only, one more cycle to take the data byte.

A stop instruction, or an unknown opcode, parks the core until the next reset.

Top module: `tiny_cpu_core`

## Requirements
- R1: During and directly after a synchronous reset (rst_n low at a clock edge), pc reads 0, halted reads 0, all four registers read 0 and mem_we is 0.
- R2: The first instruction byte is read from address pc and the second from pc+1. The opcode is bits [7:4] of the first byte. pc advances by 2 for each instruction before that instruction executes, so a program at address 12 runs at 12, 14, 16, 18 and 20.
- R3: Load (opcode 0001) copies the memory byte at the address in the second byte into the register named in bits [3:0] of the first byte.
- R4: Store (opcode 0011) writes the register named in bits [3:0] of the first byte into memory at the address in the second byte.
- R5: Add (opcode 0010) writes the sum of two registers into a third register. The first source is named in bits [3:0] of the first byte, the second source in bits [7:4] of the second byte, and the destination in bits [3:0] of the second byte. The sum wraps modulo 256.
- R6: Jump (opcode 1011) loads the second byte into pc.
- R7: Jump-if-equal (opcode 1100) compares the register with index bits [3:2] of the first byte against the register with index bits [1:0] of the first byte. Indices are 0 to 3 and mean R1 to R4. When the two registers are equal, the second byte is loaded into pc; otherwise execution continues at the next instruction.
- R8: Opcode 0000, and any opcode not listed above, sets halted. pc then holds the address after the stopping instruction. After that, pc, the registers and memory stay unchanged and halted stays 1 until reset.
- R9: In load, store and add, a 4-bit register field with value n from 1 to 4 selects register Rn.
- R10: dbg_data shows register R(dbg_sel+1) combinationally.
- R11: Read data is taken one cycle after the address is driven. Every instruction takes 4 cycles, except load, which takes 5. Counted from reset release, halted rises on the edge that ends the stopping instruction's fourth cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 8 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| halted | output | 1 | Core has stopped |
| pc | output | 8 | Program counter |
| dbg_sel | input | 2 | Register read-back select (0 = R1 ... 3 = R4) |
| dbg_data | output | 8 | Selected register value |

## Verification
The bench first runs the six-instruction sample program placed at address 12 and checks the result byte, the final pc and the cycle count. A core that read the register field from the wrong nibble, or added the wrong cycle for loads, would give a wrong value or a wrong timing. Directed programs target the equal and unequal outcomes of the conditional jump, a sum past 255, and an unknown opcode. A core that inverted the comparison, kept the carry, or ran past a bad opcode would leave different memory or a different pc. Random straight-line programs that mix loads, stores, adds and forward jumps are compared with an instruction-level model after each run. The bench also confirms that nothing moves after halt, which catches a core whose pc or memory writes continue in the stopped state.

// File: rtl/tcpu_pkg.sv
// Shared constants and types for the two-byte processor core.
// Assumes 8-bit data and addresses and four general registers.
package tcpu_pkg;
    localparam int DATA_W = 8;
    localparam int NREG   = 4;
    localparam int RIDX_W = $clog2(NREG);
    localparam int INSN_W = 2 * DATA_W;

    typedef enum logic [3:0] {
        OPC_STOP  = 4'h0,
        OPC_LOAD  = 4'h1,
        OPC_ADD   = 4'h2,
        OPC_STORE = 4'h3,
        OPC_JMP   = 4'hB,
        OPC_JEQ   = 4'hC
    } opc_e;

    typedef enum logic [2:0] {
        S_FETCH0,
        S_FETCH1,
        S_DECODE,
        S_EXEC,
        S_MEMRD,
        S_STOPPED
    } state_e;

    typedef struct packed {
        logic              do_load;
        logic              do_store;
        logic              do_add;
        logic              do_jmp;
        logic              do_jeq;
        logic              do_stop;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] src_b;
        logic [RIDX_W-1:0] dst;
    } ctl_t;
endpackage

// File: rtl/tcpu_decode.sv
// Instruction decoder: turns the 16-bit instruction word into one-hot
// operation flags and register indices. Assumes register fields hold 1..4
// (load/store/add) or packed 2-bit indices (jump-if-equal). Unknown opcodes
// decode as stop.
module tcpu_decode
    import tcpu_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output ctl_t              ctl
);
    logic [3:0] opc;
    assign opc = insn[15:12];

    // Field extraction and opcode classification.
    always_comb begin
        ctl          = '0;
        ctl.src_a    = RIDX_W'(insn[11:8] - 4'd1);
        ctl.src_b    = RIDX_W'(insn[7:4] - 4'd1);
        ctl.dst      = RIDX_W'(insn[3:0] - 4'd1);
        unique case (opc)
            OPC_LOAD:  begin ctl.do_load  = 1'b1; ctl.dst = RIDX_W'(insn[11:8] - 4'd1); end
            OPC_STORE: ctl.do_store = 1'b1;
            OPC_ADD:   ctl.do_add   = 1'b1;
            OPC_JMP:   ctl.do_jmp   = 1'b1;
            OPC_JEQ:   begin
                ctl.do_jeq = 1'b1;
                ctl.src_a  = insn[11:10];
                ctl.src_b  = insn[9:8];
            end
            default:   ctl.do_stop  = 1'b1;
        endcase
    end
endmodule

// File: rtl/tcpu_regfile.sv
// General register file: NREG registers, two combinational read ports for
// execution, one for test read-back, one synchronous write port.
// Assumes synchronous active-low reset clears every register.
module tcpu_regfile
    import tcpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [RIDX_W-1:0] rd_a_idx,
    input  logic [RIDX_W-1:0] rd_b_idx,
    input  logic [RIDX_W-1:0] rd_t_idx,
    output logic [DATA_W-1:0] rd_a_val,
    output logic [DATA_W-1:0] rd_b_val,
    output logic [DATA_W-1:0] rd_t_val
);
    logic [DATA_W-1:0] cells_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        // Hold one register; load it when addressed by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells_q[g] <= '0;
            else if (wr_en && wr_idx == RIDX_W'(g))
                cells_q[g] <= wr_val;
        end
    end

    assign rd_a_val = cells_q[rd_a_idx];
    assign rd_b_val = cells_q[rd_b_idx];
    assign rd_t_val = cells_q[rd_t_idx];

    // R9: a write lands in exactly the addressed register.
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cells_q[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/tcpu_alu.sv
// Arithmetic unit: wrapping adder and equality compare for the core.
// Assumes unsigned operands of W bits; carry out is discarded.
module tcpu_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum,
    output logic         same
);
    // Modulo-2^W sum and equality flag.
    always_comb begin
        sum  = opa + opb;
        same = (opa == opb);
    end
endmodule

// File: rtl/tiny_cpu_core.sv
// Multi-cycle two-byte stored-program core. Walks fetch0, fetch1, decode,
// execute and (loads only) a read-data state. Assumes a synchronous memory
// whose read data appears one cycle after the address.
module tiny_cpu_core
    import tcpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    output logic [DATA_W-1:0] pc,
    input  logic [RIDX_W-1:0] dbg_sel,
    output logic [DATA_W-1:0] dbg_data
);
    state_e            st_q, st_d;
    logic [DATA_W-1:0] pc_q;
    logic [INSN_W-1:0] ir_q;
    logic              stop_q;
    ctl_t              ctl;
    logic [DATA_W-1:0] va, vb, sum;
    logic              same;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_widx;
    logic [DATA_W-1:0] rf_wval;
    logic [DATA_W-1:0] tgt;

    assign tgt = ir_q[DATA_W-1:0];

    tcpu_decode u_dec (.insn(ir_q), .ctl(ctl));

    tcpu_regfile u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rf_we), .wr_idx(rf_widx), .wr_val(rf_wval),
        .rd_a_idx(ctl.src_a), .rd_b_idx(ctl.src_b), .rd_t_idx(dbg_sel),
        .rd_a_val(va), .rd_b_val(vb), .rd_t_val(dbg_data)
    );

    tcpu_alu #(.W(DATA_W)) u_alu (.opa(va), .opb(vb), .sum(sum), .same(same));

    // Register-file write source: add result in execute, memory byte for loads.
    always_comb begin
        rf_we   = (st_q == S_EXEC && ctl.do_add) || (st_q == S_MEMRD);
        rf_widx = ctl.dst;
        rf_wval = (st_q == S_MEMRD) ? mem_rdata : sum;
    end

    // Memory port drive per state.
    always_comb begin
        mem_addr  = pc_q;
        mem_wdata = va;
        mem_we    = 1'b0;
        unique case (st_q)
            S_FETCH1: mem_addr = pc_q + DATA_W'(1);
            S_EXEC:   begin
                mem_addr = tgt;
                mem_we   = ctl.do_store;
            end
            default:  mem_addr = pc_q;
        endcase
    end

    // Next-state selection of the instruction walk.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_FETCH0:  st_d = S_FETCH1;
            S_FETCH1:  st_d = S_DECODE;
            S_DECODE:  st_d = S_EXEC;
            S_EXEC:    st_d = ctl.do_stop ? S_STOPPED : (ctl.do_load ? S_MEMRD : S_FETCH0);
            S_MEMRD:   st_d = S_FETCH0;
            default:   st_d = S_STOPPED;
        endcase
    end

    // State, program counter, instruction register and stop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_FETCH0;
            pc_q   <= '0;
            ir_q   <= '0;
            stop_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == S_FETCH1)
                ir_q[INSN_W-1:DATA_W] <= mem_rdata;
            if (st_q == S_DECODE) begin
                ir_q[DATA_W-1:0] <= mem_rdata;
                pc_q             <= pc_q + DATA_W'(2);
            end
            if (st_q == S_EXEC) begin
                if (ctl.do_jmp || (ctl.do_jeq && same))
                    pc_q <= tgt;
                if (ctl.do_stop)
                    stop_q <= 1'b1;
            end
        end
    end

    assign halted = stop_q;
    assign pc     = pc_q;

    // R8: once stopped, the core stays stopped.
    a_r8_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    // R8: the program counter is frozen while stopped.
    a_r8_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));
    // R8: no memory writes while stopped.
    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
    // R2: decode advances the program counter by two.
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DECODE) |=> pc == $past(pc) + DATA_W'(2));
    // R6: an unconditional jump takes the second instruction byte.
    a_r6_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXEC && ctl.do_jmp) |=> pc == $past(tgt));
    // R9: exactly one operation is decoded at execute.
    a_r9_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXEC) |-> $onehot({ctl.do_load, ctl.do_store, ctl.do_add,
                                      ctl.do_jmp, ctl.do_jeq, ctl.do_stop}));
endmodule

// File: tb/tb_tiny_cpu_core.sv
`timescale 1ns/1ps
module tb_tiny_cpu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, pc, dbg_data;
    logic       mem_we, halted;
    logic [1:0] dbg_sel = 2'd0;

    logic [7:0] mem [256];
    logic [7:0] img [256];
    logic [7:0] ref_mem [256];
    logic [7:0] ref_r [4];
    logic       copy_img = 1'b0;
    int         total = 0;
    int         bad = 0;
    int         cycles_all = 0;

    always #4 clk = ~clk;

    tiny_cpu_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .pc(pc),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data)
    );

    // Bench memory: synchronous read, one-cycle latency, bulk preload.
    always @(posedge clk) begin
        if (copy_img) begin
            for (int i = 0; i < 256; i++) mem[i] <= img[i];
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles_all <= cycles_all + 1;
        if (cycles_all > 190000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=<190000", cycles_all);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] ri(logic [3:0] f);
        return 2'(f - 4'd1);
    endfunction

    function automatic logic [7:0] rd_reg(int n);
        return 8'd0;
    endfunction

    task automatic read_reg(int n, output logic [7:0] v);
        @(negedge clk);
        dbg_sel = 2'(n);
        #1;
        v = dbg_data;
    endtask

    // Copy image into memory under reset, then release at a falling edge.
    task automatic start_run();
        @(negedge clk);
        rst_n = 1'b0;
        copy_img = 1'b1;
        @(negedge clk);
        copy_img = 1'b0;
        @(negedge clk);
    endtask

    task automatic release_and_run(output int cyc);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
    endtask

    // Instruction-level reference model on ref_mem/ref_r.
    task automatic ref_run(output int rpc, output int rcyc);
        logic [7:0] p, b0, b1;
        p = 8'd0;
        rcyc = 0;
        for (int k = 0; k < 4; k++) ref_r[k] = 8'd0;
        for (int s = 0; s < 400; s++) begin
            b0 = ref_mem[p];
            b1 = ref_mem[8'(p + 8'd1)];
            p = 8'(p + 8'd2);
            rcyc += 4;
            case (b0[7:4])
                4'h1: begin ref_r[ri(b0[3:0])] = ref_mem[b1]; rcyc += 1; end
                4'h2: ref_r[ri(b1[3:0])] = 8'(ref_r[ri(b0[3:0])] + ref_r[ri(b1[7:4])]);
                4'h3: ref_mem[b1] = ref_r[ri(b0[3:0])];
                4'hB: p = b1;
                4'hC: if (ref_r[b0[3:2]] == ref_r[b0[1:0]]) p = b1;
                default: break;
            endcase
        end
        rpc = int'(p);
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'd0;
    endtask

    // Build a random forward-only program at 0 with random data at 128..255.
    task automatic gen_prog();
        int n, kind, t;
        logic [3:0] a, b, d;
        clear_img();
        for (int i = 128; i < 256; i++) img[i] = 8'($urandom);
        n = 4 + int'($urandom % 20);
        for (int k = 0; k < n; k++) begin
            kind = int'($urandom % 7);
            a = 4'(1 + $urandom % 4);
            b = 4'(1 + $urandom % 4);
            d = 4'(1 + $urandom % 4);
            t = 2 * k + 4 + 2 * int'($urandom % 3);
            if (t > 2 * n) t = 2 * n;
            case (kind)
                0, 1: begin img[2*k] = {4'h1, a}; img[2*k+1] = 8'(128 + $urandom % 128); end
                2:    begin img[2*k] = {4'h3, a}; img[2*k+1] = 8'(128 + $urandom % 128); end
                3, 4: begin img[2*k] = {4'h2, a}; img[2*k+1] = {b, d}; end
                5:    begin
                    img[2*k] = {4'hC, 2'(a - 1), ($urandom % 2 == 0) ? 2'(a - 1) : 2'(b - 1)};
                    img[2*k+1] = 8'(t);
                end
                default: begin img[2*k] = 8'hB0; img[2*k+1] = 8'(t); end
            endcase
        end
        img[2*n] = ($urandom % 3 == 0) ? 8'(8'h40 + ($urandom % 7) * 16) : 8'h00;
        img[2*n+1] = 8'd0;
    endtask

    task automatic compare_to_ref(string tag, int cyc);
        int rpc, rcyc, mism;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) ref_mem[i] = img[i];
        ref_run(rpc, rcyc);
        chk({tag, " R2 R8 final pc"}, int'(pc), rpc);
        chk({tag, " R11 cycles"}, cyc, rcyc);
        chk({tag, " R8 halted"}, int'(halted), 1);
        for (int k = 0; k < 4; k++) begin
            read_reg(k, v);
            chk({tag, " R3 R5 R10 register"}, int'(v), int'(ref_r[k]));
        end
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mism++;
        chk({tag, " R4 memory mismatches"}, mism, 0);
    endtask

    initial begin
        int cyc;
        logic [7:0] v;
        void'($urandom(32'd4242));

        // R1: reset state.
        clear_img();
        start_run();
        chk("R1 pc at reset", int'(pc), 0);
        chk("R1 halted at reset", int'(halted), 0);
        chk("R1 mem_we at reset", int'(mem_we), 0);
        for (int k = 0; k < 4; k++) begin
            read_reg(k, v);
            chk("R1 R10 register at reset", int'(v), 0);
        end

        // Sample program at 12, reached by a jump at 0 (R6).
        clear_img();
        img[0] = 8'hB0; img[1] = 8'd12;
        img[12] = 8'h13; img[13] = 8'd108;
        img[14] = 8'h14; img[15] = 8'd109;
        img[16] = 8'h23; img[17] = 8'h41;
        img[18] = 8'h31; img[19] = 8'd110;
        img[20] = 8'h00; img[21] = 8'h00;
        img[108] = 8'd35; img[109] = 8'd77;
        start_run();
        release_and_run(cyc);
        chk("R4 R5 sum stored at 110", int'(mem[110]), 112);
        chk("R2 R6 R8 pc after stop", int'(pc), 22);
        chk("R11 sample cycle count", cyc, 26);
        read_reg(0, v); chk("R5 R9 R1 holds sum", int'(v), 112);
        read_reg(2, v); chk("R3 R9 R3 loaded", int'(v), 35);
        read_reg(3, v); chk("R3 R10 R4 loaded", int'(v), 77);
        repeat (20) @(negedge clk);
        chk("R8 pc frozen", int'(pc), 22);
        chk("R8 halted stays", int'(halted), 1);
        chk("R8 memory frozen", int'(mem[110]), 112);
        read_reg(0, v); chk("R8 register frozen", int'(v), 112);

        // R5: wrap modulo 256.
        clear_img();
        img[0] = 8'h11; img[1] = 8'd200;
        img[2] = 8'h12; img[3] = 8'd201;
        img[4] = 8'h21; img[5] = 8'h23;
        img[6] = 8'h33; img[7] = 8'd202;
        img[200] = 8'd200; img[201] = 8'd100;
        start_run();
        release_and_run(cyc);
        chk("R5 wrapped sum", int'(mem[202]), 44);

        // R7: jump-if-equal taken, then not taken.
        for (int pass = 0; pass < 2; pass++) begin
            clear_img();
            img[0] = 8'h11; img[1] = 8'd200;
            img[2] = 8'h12; img[3] = 8'd201;
            img[4] = 8'hC1; img[5] = 8'd10;
            img[6] = 8'h31; img[7] = 8'd210;
            img[10] = 8'h32; img[11] = 8'd211;
            img[200] = 8'd5; img[201] = (pass == 0) ? 8'd5 : 8'd6;
            start_run();
            release_and_run(cyc);
            if (pass == 0) begin
                chk("R7 taken skips store", int'(mem[210]), 0);
                chk("R7 taken target store", int'(mem[211]), 5);
                chk("R7 taken pc", int'(pc), 14);
            end else begin
                chk("R7 not taken store", int'(mem[210]), 5);
                chk("R7 not taken no target", int'(mem[211]), 0);
                chk("R7 not taken pc", int'(pc), 10);
            end
        end

        // R8: unknown opcode stops.
        clear_img();
        img[0] = 8'h70; img[1] = 8'h11;
        img[2] = 8'h31; img[3] = 8'd100;
        start_run();
        release_and_run(cyc);
        chk("R8 unknown opcode halts", int'(halted), 1);
        chk("R8 unknown opcode pc", int'(pc), 2);
        chk("R11 unknown opcode cycles", cyc, 4);

        // Random programs against the reference model.
        for (int p = 0; p < 40; p++) begin
            gen_prog();
            start_run();
            release_and_run(cyc);
            compare_to_ref("random", cyc);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule